// File: doc/BRIEF.md
# Three-Level Affine Pattern Address Generator

This block turns a tree of three-dimensional access descriptors into a stream of word addresses. Each descriptor names a starting displacement and three nested loop counts: a run of consecutive words, a number of such runs spaced by a row pitch, and a number of such planes spaced by a plane gap. Descriptors live in a small on-block table loaded through a write port, and each one carries two links. The child link names a descriptor that runs once for every position of its parent. The sibling link names a descriptor that runs after this one, under the same parent.

A consumer pulses `start` with the slot of the root descriptor. The generator walks the tree depth first. A descriptor with a live child emits nothing of its own. Each of its positions becomes the base that the child subtree adds its own offsets to, so higher levels set where lower-level patterns land. Leaf descriptors emit one address per accepted cycle through a valid/ready pair. The final address of the tree carries a last flag, and `busy` drops right after that address is taken.

Top module: `affine_tree_agen`

## Requirements
- R1: After reset `busy`, `out_valid` and `out_last` are 0, and every table slot holds offset 0, all sizes 0 and both links null.
- R2: A leaf descriptor written at slot S (fields offset, run, pitch, rows, gap, planes) emits, in order, base + offset + p*gap + r*pitch + w. Here w counts fastest, from 0 to run-1, then r from 0 to rows-1, then p from 0 to planes-1. Arithmetic is modulo 2^16, and the root base is 0.
- R3: A size field (run, rows or planes) equal to 0 acts as a count of 1.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_addr` and `out_last` hold their values and no address is skipped.
- R5: Within one leaf with `out_ready` held at 1, addresses come out on consecutive cycles, so a lone root leaf of N addresses keeps `busy` high for exactly N cycles.
- R6: A descriptor whose child link is not null emits no address of its own. For each of its positions, in R2 order, the child subtree runs with that position as its base.
- R7: When a descriptor's pattern ends and its sibling link is not null, the sibling runs next with the same base as the descriptor it follows. This includes siblings of the root.
- R8: The link value 15 (all ones, 4-bit slot) is null and ends a chain. Every address that the tree defines appears exactly once, and no others appear.
- R9: `out_last` is 1 only with `out_valid`, and only on the final address of the tree. `busy` falls on the cycle after that address is accepted and at no other time.
- R10: A `start` pulse while `busy` is 1 is ignored, and the running sequence goes on unchanged.
- R11: A descriptor reached at nesting level STACK_DEPTH-1 (root is level 0, default 4 levels) is treated as a leaf, and its child link is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one descriptor into the table |
| wr_slot | input | 4 | Table slot written |
| wr_offset | input | 16 | Start displacement from the base |
| wr_run | input | 8 | Consecutive words per run (0 means 1) |
| wr_pitch | input | 16 | Distance between run starts |
| wr_rows | input | 8 | Runs per plane (0 means 1) |
| wr_gap | input | 16 | Distance between plane starts |
| wr_planes | input | 8 | Planes per pattern (0 means 1) |
| wr_sib | input | 4 | Sibling link, 15 = null |
| wr_child | input | 4 | Child link, 15 = null |
| start | input | 1 | Begin a walk at `start_slot` when idle |
| start_slot | input | 4 | Root descriptor slot |
| busy | output | 1 | A walk is in progress |
| out_valid | output | 1 | `out_addr` is offered |
| out_ready | input | 1 | Consumer takes the offered address |
| out_addr | output | 16 | Generated word address |
| out_last | output | 1 | Offered address is the tree's final one |

## Verification
The hardest situation to reach from the ports is a leaf that ends while every ancestor is also on its final position with no sibling. Only then must the last flag appear, and it depends on state spread across the whole walk stack. The bench builds trees where an inner level has further siblings and extra positions after a leaf completes, so a flag that looked only at the leaf would fire early. It also builds a five-deep chain that runs into the nesting limit. These trees are repeated under a pseudo-random ready pattern, so that stalls land on level transitions and on the final address.

// File: rtl/agen_pkg.sv
package agen_pkg;

    localparam int AG_ADDR_W = 16;
    localparam int AG_CNT_W  = 8;
    localparam int AG_SLOT_W = 4;
    localparam int AG_SLOTS  = 2 ** AG_SLOT_W;

    typedef logic [AG_ADDR_W-1:0] addr_t;
    typedef logic [AG_CNT_W-1:0]  cnt_t;
    typedef logic [AG_SLOT_W-1:0] slot_t;

    localparam slot_t AG_NULL = '1;

    // One stored pattern descriptor
    typedef struct packed {
        addr_t offset;
        cnt_t  run;
        addr_t pitch;
        cnt_t  rows;
        addr_t gap;
        cnt_t  planes;
        slot_t sib;
        slot_t child;
    } desc_t;

    // Live iteration state of one tree level
    typedef struct packed {
        desc_t d;
        cnt_t  hc;
        cnt_t  vc;
        cnt_t  dc;
        addr_t base;
        addr_t row;
        addr_t plane;
        addr_t cur;
    } frame_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_RETIRE = 2'd2
    } walk_state_e;

    // True when counter c sits on its final value; a size of zero counts once
    function automatic logic axis_end(cnt_t c, cnt_t s);
        return (s == '0) || (c == s - cnt_t'(1));
    endfunction

    // Begin iterating descriptor d relative to base b
    function automatic frame_t frame_open(desc_t d, addr_t b);
        frame_t f;
        f       = '0;
        f.d     = d;
        f.base  = b;
        f.cur   = b + d.offset;
        f.row   = f.cur;
        f.plane = f.cur;
        return f;
    endfunction

endpackage

// File: rtl/agen_desc_store.sv
module agen_desc_store
    import agen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  slot_t wr_slot,
    input  desc_t wr_desc,
    input  slot_t rd_slot,
    output desc_t rd_desc
);

    desc_t table_q [AG_SLOTS];
    desc_t blank;

    always_comb begin
        blank       = '0;
        blank.sib   = AG_NULL;
        blank.child = AG_NULL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < AG_SLOTS; i++) begin
                table_q[i] <= blank;
            end
        end else if (wr_en) begin
            table_q[wr_slot] <= wr_desc;
        end
    end

    assign rd_desc = table_q[rd_slot];

endmodule

// File: rtl/agen_step.sv
module agen_step
    import agen_pkg::*;
(
    input  frame_t f,
    output frame_t f_nxt,
    output logic   wrap
);

    logic h_end, v_end, d_end;

    always_comb begin
        h_end = axis_end(f.hc, f.d.run);
        v_end = axis_end(f.vc, f.d.rows);
        d_end = axis_end(f.dc, f.d.planes);
        wrap  = h_end && v_end && d_end;
        f_nxt = f;
        if (!h_end) begin
            f_nxt.hc  = f.hc + cnt_t'(1);
            f_nxt.cur = f.cur + addr_t'(1);
        end else if (!v_end) begin
            f_nxt.hc  = '0;
            f_nxt.vc  = f.vc + cnt_t'(1);
            f_nxt.row = f.row + f.d.pitch;
            f_nxt.cur = f.row + f.d.pitch;
        end else if (!d_end) begin
            f_nxt.hc    = '0;
            f_nxt.vc    = '0;
            f_nxt.dc    = f.dc + cnt_t'(1);
            f_nxt.plane = f.plane + f.d.gap;
            f_nxt.row   = f.plane + f.d.gap;
            f_nxt.cur   = f.plane + f.d.gap;
        end
    end

endmodule

// File: rtl/affine_tree_agen.sv
module affine_tree_agen
    import agen_pkg::*;
#(
    parameter int STACK_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [AG_SLOT_W-1:0] wr_slot,
    input  logic [AG_ADDR_W-1:0] wr_offset,
    input  logic [AG_CNT_W-1:0]  wr_run,
    input  logic [AG_ADDR_W-1:0] wr_pitch,
    input  logic [AG_CNT_W-1:0]  wr_rows,
    input  logic [AG_ADDR_W-1:0] wr_gap,
    input  logic [AG_CNT_W-1:0]  wr_planes,
    input  logic [AG_SLOT_W-1:0] wr_sib,
    input  logic [AG_SLOT_W-1:0] wr_child,
    input  logic                 start,
    input  logic [AG_SLOT_W-1:0] start_slot,
    output logic                 busy,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [AG_ADDR_W-1:0] out_addr,
    output logic                 out_last
);

    localparam int SP_W = (STACK_DEPTH > 2) ? $clog2(STACK_DEPTH) : 1;
    localparam logic [SP_W-1:0] SP_TOP = SP_W'(STACK_DEPTH - 1);

    walk_state_e   st;
    frame_t        stk   [STACK_DEPTH];
    frame_t        nxt   [STACK_DEPTH];
    logic [STACK_DEPTH-1:0] wrp;
    logic [STACK_DEPTH-1:0] fin_or_above;
    logic [SP_W-1:0] sp;

    desc_t  wr_desc;
    desc_t  rd_desc;
    slot_t  rd_slot;
    frame_t top;
    frame_t top_nxt;
    logic   top_wrap;
    logic   is_node;
    logic   chain_final;
    logic   fire;
    logic   has_sib;

    always_comb begin
        wr_desc.offset = wr_offset;
        wr_desc.run    = wr_run;
        wr_desc.pitch  = wr_pitch;
        wr_desc.rows   = wr_rows;
        wr_desc.gap    = wr_gap;
        wr_desc.planes = wr_planes;
        wr_desc.sib    = wr_sib;
        wr_desc.child  = wr_child;
    end

    agen_desc_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_desc (wr_desc),
        .rd_slot (rd_slot),
        .rd_desc (rd_desc)
    );

    // One stepping unit per level: the top one advances, all of them
    // report whether their level is on its final position.
    for (genvar j = 0; j < STACK_DEPTH; j++) begin : g_lvl
        agen_step u_step (
            .f     (stk[j]),
            .f_nxt (nxt[j]),
            .wrap  (wrp[j])
        );
        assign fin_or_above[j] = (SP_W'(j) > sp) ||
                                 (wrp[j] && (stk[j].d.sib == AG_NULL));
    end

    always_comb begin
        top         = stk[sp];
        top_nxt     = nxt[sp];
        top_wrap    = wrp[sp];
        has_sib     = (top.d.sib != AG_NULL);
        is_node     = (top.d.child != AG_NULL) && (sp != SP_TOP);
        chain_final = &fin_or_above;
        out_valid   = (st == ST_RUN) && !is_node;
        out_addr    = top.cur;
        out_last    = out_valid && chain_final;
        fire        = out_valid && out_ready;
        busy        = (st != ST_IDLE);
        if (st == ST_IDLE)
            rd_slot = start_slot;
        else if (st == ST_RUN && is_node)
            rd_slot = top.d.child;
        else
            rd_slot = top.d.sib;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
            sp <= '0;
            for (int i = 0; i < STACK_DEPTH; i++) begin
                stk[i] <= '0;
            end
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        stk[0] <= frame_open(rd_desc, '0);
                        sp     <= '0;
                        st     <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (is_node) begin
                        stk[sp + SP_W'(1)] <= frame_open(rd_desc, top.cur);
                        sp                 <= sp + SP_W'(1);
                    end else if (fire) begin
                        if (out_last) begin
                            st <= ST_IDLE;
                        end else if (!top_wrap) begin
                            stk[sp] <= top_nxt;
                        end else if (has_sib) begin
                            stk[sp] <= frame_open(rd_desc, top.base);
                        end else if (sp == '0) begin
                            st <= ST_IDLE;
                        end else begin
                            sp <= sp - SP_W'(1);
                            st <= ST_RETIRE;
                        end
                    end
                end
                ST_RETIRE: begin
                    if (!top_wrap) begin
                        stk[sp] <= top_nxt;
                        st      <= ST_RUN;
                    end else if (has_sib) begin
                        stk[sp] <= frame_open(rd_desc, top.base);
                        st      <= ST_RUN;
                    end else if (sp == '0) begin
                        st <= ST_IDLE;
                    end else begin
                        sp <= sp - SP_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/agen_chk.sv
module agen_chk
    import agen_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 busy,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [AG_ADDR_W-1:0] out_addr,
    input logic                 out_last
);

    a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_addr) && $stable(out_last)));

    a_r9_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    a_r9_idle_after_last: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !busy);

    a_r9_fall_only_after_last: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(out_valid && out_ready && out_last));

    a_r1_valid_inside_walk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);

endmodule

bind affine_tree_agen agen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_last  (out_last)
);

// File: tb/affine_tree_agen_bench.sv
module affine_tree_agen_bench;
    import agen_pkg::*;

    localparam int DEPTH = 4;
    localparam int NUL   = 15;

    logic clk = 0;
    logic rst = 1;
    always #4 clk = ~clk;

    logic        wr_en = 0;
    logic [3:0]  wr_slot = 0;
    logic [15:0] wr_offset = 0, wr_pitch = 0, wr_gap = 0;
    logic [7:0]  wr_run = 0, wr_rows = 0, wr_planes = 0;
    logic [3:0]  wr_sib = 0, wr_child = 0;
    logic        start = 0;
    logic [3:0]  start_slot = 0;
    logic        busy, out_valid, out_last;
    logic        out_ready = 1;
    logic [15:0] out_addr;

    affine_tree_agen #(.STACK_DEPTH(DEPTH)) u_affine_tree_agen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_offset(wr_offset), .wr_run(wr_run), .wr_pitch(wr_pitch),
        .wr_rows(wr_rows), .wr_gap(wr_gap), .wr_planes(wr_planes),
        .wr_sib(wr_sib), .wr_child(wr_child), .start(start),
        .start_slot(start_slot), .busy(busy), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr), .out_last(out_last)
    );

    int checks = 0;
    int errors = 0;
    bit rnd_ready = 0;
    bit last_seen = 0;
    logic [7:0] lfsr = 8'h5a;

    // bench copy of the descriptor table
    logic [15:0] m_off [16], m_pitch [16], m_gap [16];
    int          m_run [16], m_rows [16], m_planes [16], m_sib [16], m_child [16];
    logic [15:0] exp_q [$];

    function automatic int eff(int n);
        return (n == 0) ? 1 : n;
    endfunction

    function automatic void expand(int slot, logic [15:0] base, int lvl);
        int s = slot;
        while (s != NUL) begin
            for (int p = 0; p < eff(m_planes[s]); p++)
                for (int r = 0; r < eff(m_rows[s]); r++)
                    for (int w = 0; w < eff(m_run[s]); w++) begin
                        logic [15:0] pos;
                        pos = base + m_off[s] + 16'(p) * m_gap[s]
                              + 16'(r) * m_pitch[s] + 16'(w);
                        if (m_child[s] != NUL && lvl < DEPTH - 1)
                            expand(m_child[s], pos, lvl + 1);
                        else
                            exp_q.push_back(pos);
                    end
            s = m_sib[s];
        end
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic put_desc(input int slot, input logic [15:0] off, input int run,
                            input logic [15:0] pitch, input int rows,
                            input logic [15:0] gap, input int planes,
                            input int sib, input int child);
        m_off[slot] = off; m_run[slot] = run; m_pitch[slot] = pitch;
        m_rows[slot] = rows; m_gap[slot] = gap; m_planes[slot] = planes;
        m_sib[slot] = sib; m_child[slot] = child;
        @(negedge clk);
        wr_en = 1; wr_slot = 4'(slot); wr_offset = off; wr_run = 8'(run);
        wr_pitch = pitch; wr_rows = 8'(rows); wr_gap = gap; wr_planes = 8'(planes);
        wr_sib = 4'(sib); wr_child = 4'(child);
        @(negedge clk);
        wr_en = 0;
    endtask

    // driver: builds the expectation, starts a walk, optionally pokes start mid-walk
    task automatic run_tree(input int slot, input bit poke, output int bcycles);
        int wd = 0;
        exp_q.delete();
        expand(slot, 16'h0, 0);
        last_seen = 0;
        @(negedge clk);
        start = 1; start_slot = 4'(slot);
        @(negedge clk);
        start = 0;
        bcycles = 0;
        while (busy && wd < 20000) begin
            bcycles++;
            wd++;
            if (poke && bcycles == 3) begin
                start = 1; start_slot = 4'(0);
            end else begin
                start = 0;
            end
            @(negedge clk);
        end
        start = 0;
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R8 all addresses produced", exp_q.size(), 0);
        check(last_seen, "R9 final flag seen", int'(last_seen), 1);
        check(!out_valid && !busy, "R9 quiet after end", int'(out_valid), 0);
    endtask

    // ready pattern, updated just after each active edge
    initial begin
        forever begin
            @(posedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready <= rnd_ready ? lfsr[0] : 1'b1;
        end
    end

    // monitor: pops and compares every accepted address
    logic        hold_v = 0;
    logic [15:0] hold_addr;
    logic        hold_last;
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_v) begin
                checks++;
                if (!(out_valid && out_addr == hold_addr && out_last == hold_last)) begin
                    errors++;
                    $display("FAIL R4 stall hold actual=%0h expected=%0h", out_addr, hold_addr);
                end
            end
            hold_v    = out_valid && !out_ready;
            hold_addr = out_addr;
            hold_last = out_last;
            if (out_valid && out_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R8 extra address actual=%0h expected=none", out_addr);
                end else begin
                    logic [15:0] e;
                    bit el;
                    e  = exp_q.pop_front();
                    el = (exp_q.size() == 0);
                    if (out_addr !== e || out_last !== el) begin
                        errors++;
                        $display("FAIL R2 address/last actual=%0h/%0b expected=%0h/%0b",
                                 out_addr, out_last, e, el);
                    end
                    if (out_last) last_seen = 1;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int bc;
        for (int i = 0; i < 16; i++) begin
            m_off[i] = 0; m_run[i] = 0; m_pitch[i] = 0; m_rows[i] = 0;
            m_gap[i] = 0; m_planes[i] = 0; m_sib[i] = NUL; m_child[i] = NUL;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state and blank table slot (one address at 0)
        check(!busy && !out_valid && !out_last, "R1 reset outputs", int'(busy), 0);
        run_tree(12, 0, bc);
        check(bc == 1, "R1 blank slot single address", bc, 1);

        // R2 / R5: single leaf, 4 x 2 x 2 = 16 addresses back to back
        put_desc(0, 16'h0100, 4, 16'h0010, 2, 16'h0100, 2, NUL, NUL);
        run_tree(0, 0, bc);
        check(bc == 16, "R5 one address per cycle", bc, 16);

        // R3: zero sizes count as one
        put_desc(10, 16'h0300, 0, 16'h0008, 0, 16'h0040, 3, NUL, NUL);
        run_tree(10, 0, bc);
        check(bc == 3, "R3 zero run and rows", bc, 3);
        put_desc(11, 16'h0055, 0, 16'h0000, 0, 16'h0000, 0, NUL, NUL);
        run_tree(11, 0, bc);
        check(bc == 1, "R3 all sizes zero", bc, 1);

        // R6 / R7: parent with child chain and root sibling
        put_desc(1, 16'h1000, 2, 16'h0040, 2, 16'h0000, 1, 4, 2);
        put_desc(2, 16'h0004, 3, 16'h0000, 1, 16'h0000, 1, 3, NUL);
        put_desc(3, 16'h0020, 1, 16'h0008, 2, 16'h0000, 1, NUL, NUL);
        put_desc(4, 16'h5000, 2, 16'h0000, 1, 16'h0000, 1, NUL, NUL);
        run_tree(1, 0, bc);

        // R11: five-deep chain, fourth level acts as leaf
        put_desc(5, 16'h0100, 1, 0, 1, 0, 1, NUL, 6);
        put_desc(6, 16'h0010, 1, 0, 1, 0, 1, NUL, 7);
        put_desc(7, 16'h0001, 1, 0, 1, 0, 1, NUL, 8);
        put_desc(8, 16'h2000, 2, 0, 1, 0, 1, NUL, 9);
        put_desc(9, 16'h7000, 1, 0, 1, 0, 1, NUL, NUL);
        run_tree(5, 0, bc);

        // R4: same trees with a stalling consumer
        rnd_ready = 1;
        run_tree(1, 0, bc);
        run_tree(0, 0, bc);
        run_tree(5, 0, bc);

        // R10: start pulse in mid-walk is ignored
        run_tree(1, 1, bc);
        rnd_ready = 0;
        run_tree(4, 1, bc);
        check(bc == 2, "R10 restart ignored", bc, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule